// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps a calendar and a clock: seconds, minutes, hours, day of week, day of month, month and year within the century. A one-cycle pulse on `tick_1hz` starts an update window. At the end of that window the time moves forward by one second, and every rollover is carried through in that same update. Software reaches the fields by register number. There is a synchronous write port and a combinational read port. Three more registers hold alarm seconds, minutes and hours. The block stores these and reads them back, but never compares them.

Control register 0xB picks how the fields are encoded and how the hour is shown. The encoding is binary or packed BCD, and the hour runs in 24-hour form or in 12-hour form with a PM flag. Control register 0xB also has a freeze bit that stops counting while software loads a new time. Control register 0xA has a read-only busy flag in bit 7 that tells software when a read may see a time that is about to change. Changing the mode bits never rewrites stored values.

Top module: `rtc_tod_counter`

## Requirements
- R1: After reset, the time registers read as follows: second 0x00, minute 0x00, hour 0x00, day of week 0x01, day of month 0x01, month 0x01 and year 0x00. All alarm registers read 0x00. Register 0xA reads 0x00 and register 0xB reads 0x02 (BCD, 24-hour, not frozen).
- R2: Register map: 0x0 second, 0x1 alarm second, 0x2 minute, 0x3 alarm minute, 0x4 hour, 0x5 alarm hour, 0x6 day of week, 0x7 day of month, 0x8 month, 0x9 year. Each reads back what was last written to it. Registers 0xC to 0xF read 0x00 and ignore writes.
- R3: When a tick arrives while the block is idle and not frozen, bit 7 of register 0xA is high for exactly 4 cycles, starting the cycle after the tick. The time fields take their new values in the cycle in which the flag falls.
- R4: While the busy flag is high, reads return the values from before the update. Fields change only through an update or a write.
- R5: In BCD mode (0xB bit 2 = 0), second and minute roll over from 0x59 to 0x00 and carry into the next field.
- R6: In binary mode (0xB bit 2 = 1), fields count in plain binary. For example, 9 becomes 0x0A, and 59 (0x3B) rolls over to 0.
- R7: In 24-hour mode (0xB bit 1 = 1), the hour runs 0 to 23. Rolling over from 23 advances the day of week (7 wraps to 1) and the day of month.
- R8: In 12-hour mode (0xB bit 1 = 0), the hour runs 12 AM, 1 to 11 AM, 12 PM, 1 to 11 PM. Bit 7 marks PM. The flag flips on the step from 11 to 12, and the day advances on the step from 11 PM to 12 AM.
- R9: Month lengths: months 4, 6, 9 and 11 have 30 days. February has 29 days when the year is divisible by four and 28 otherwise. All other months have 31 days. December rolls over to January and advances the year, and year 99 rolls over to 0.
- R10: While 0xB bit 7 is set, ticks are ignored: no busy flag, no change. After the bit is cleared, counting resumes with the next tick.
- R11: Changing 0xB bits 1 or 2 leaves every stored field value unchanged.
- R12: Bit 7 of register 0xA cannot be written. Bits 6:0 of 0xA are plain storage.
- R13: A tick that arrives while the busy flag is high is ignored. If a field is written in the same cycle as the update, the write wins for that field, and the carry into the other fields still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Register number for write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Register number for read |
| rd_data | output | 8 | Read data (combinational) |

## Verification
Two things can land on the same clock edge: a software write and the end of the update window, which is the edge where the busy flag falls and the fields commit. The bench provokes this by writing the seconds register exactly four cycles after a tick, with the seconds at 59 so that a carry into minutes is pending. It expects the written value in seconds and the incremented value in minutes. A second tick is also sent inside the window, and the bench checks that this tick neither stretches the flag nor adds a second increment.

// File: rtl/rtc_tod_counter.sv
`timescale 1ns/1ps
module rtc_tod_counter #(
  parameter int UIP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam int CW = $clog2(UIP_CYCLES + 1);

  logic [7:0] sec_q, asec_q, min_q, amin_q, hour_q, ahour_q;
  logic [7:0] dow_q, dom_q, mon_q, yr_q, cb_q;
  logic [6:0] ca_q;
  logic [CW-1:0] uip_cnt;

  wire uip    = uip_cnt != '0;
  wire bin_m  = cb_q[2];
  wire h24    = cb_q[1];
  wire freeze = cb_q[7];
  wire commit = (uip_cnt == CW'(1)) && !freeze;

  function automatic logic [6:0] dec(input logic [7:0] v, input logic b);
    return b ? v[6:0] : 7'(v[7:4] * 10 + v[3:0]);
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] n, input logic b);
    return b ? {1'b0, n} : {4'(n / 7'd10), 4'(n % 7'd10)};
  endfunction

  logic [6:0] s, mi, hr12, hcur, h_n, h12_n, dw, dm, mo, yr, mlen;
  logic       s_wrap, mi_wrap, h_wrap, dm_wrap, mo_wrap;
  logic [7:0] h12_enc, hour_n;

  always_comb begin
    s       = dec(sec_q, bin_m);
    mi      = dec(min_q, bin_m);
    hr12    = dec({1'b0, hour_q[6:0]}, bin_m);
    hcur    = h24 ? dec(hour_q, bin_m)
                  : ((hr12 == 7'd12) ? 7'd0 : hr12) + (hour_q[7] ? 7'd12 : 7'd0);
    dw      = dec(dow_q, bin_m);
    dm      = dec(dom_q, bin_m);
    mo      = dec(mon_q, bin_m);
    yr      = dec(yr_q, bin_m);
    s_wrap  = s >= 7'd59;
    mi_wrap = s_wrap && (mi >= 7'd59);
    h_wrap  = mi_wrap && (hcur >= 7'd23);
    h_n     = (hcur >= 7'd23) ? 7'd0 : hcur + 7'd1;
    h12_n   = (h_n == 7'd0 || h_n == 7'd12) ? 7'd12 : (h_n > 7'd12 ? h_n - 7'd12 : h_n);
    h12_enc = enc(h12_n, bin_m);
    hour_n  = h24 ? enc(h_n, bin_m) : {h_n >= 7'd12, h12_enc[6:0]};
    if (mo == 7'd2)
      mlen = (yr[1:0] == 2'd0) ? 7'd29 : 7'd28;
    else if (mo == 7'd4 || mo == 7'd6 || mo == 7'd9 || mo == 7'd11)
      mlen = 7'd30;
    else
      mlen = 7'd31;
    dm_wrap = h_wrap && (dm >= mlen);
    mo_wrap = dm_wrap && (mo >= 7'd12);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {sec_q, asec_q, min_q, amin_q, hour_q, ahour_q} <= '0;
      dow_q <= 8'h01; dom_q <= 8'h01; mon_q <= 8'h01; yr_q <= 8'h00;
      ca_q <= '0; cb_q <= 8'h02; uip_cnt <= '0;
    end else begin
      if (uip) uip_cnt <= uip_cnt - CW'(1);
      else if (tick_1hz && !freeze) uip_cnt <= CW'(UIP_CYCLES);

      if (commit) begin
        sec_q <= enc(s_wrap ? 7'd0 : s + 7'd1, bin_m);
        if (s_wrap)  min_q  <= enc((mi >= 7'd59) ? 7'd0 : mi + 7'd1, bin_m);
        if (mi_wrap) hour_q <= hour_n;
        if (h_wrap) begin
          dow_q <= enc((dw >= 7'd7) ? 7'd1 : dw + 7'd1, bin_m);
          dom_q <= enc((dm >= mlen) ? 7'd1 : dm + 7'd1, bin_m);
        end
        if (dm_wrap) mon_q <= enc((mo >= 7'd12) ? 7'd1 : mo + 7'd1, bin_m);
        if (mo_wrap) yr_q  <= enc((yr >= 7'd99) ? 7'd0 : yr + 7'd1, bin_m);
      end

      if (wr_en) begin
        case (wr_addr)
          4'h0: sec_q   <= wr_data;
          4'h1: asec_q  <= wr_data;
          4'h2: min_q   <= wr_data;
          4'h3: amin_q  <= wr_data;
          4'h4: hour_q  <= wr_data;
          4'h5: ahour_q <= wr_data;
          4'h6: dow_q   <= wr_data;
          4'h7: dom_q   <= wr_data;
          4'h8: mon_q   <= wr_data;
          4'h9: yr_q    <= wr_data;
          4'hA: ca_q    <= wr_data[6:0];
          4'hB: cb_q    <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      4'h0: rd_data = sec_q;
      4'h1: rd_data = asec_q;
      4'h2: rd_data = min_q;
      4'h3: rd_data = amin_q;
      4'h4: rd_data = hour_q;
      4'h5: rd_data = ahour_q;
      4'h6: rd_data = dow_q;
      4'h7: rd_data = dom_q;
      4'h8: rd_data = mon_q;
      4'h9: rd_data = yr_q;
      4'hA: rd_data = {uip, ca_q};
      4'hB: rd_data = cb_q;
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_tod_counter_chk.sv
`timescale 1ns/1ps
module rtc_tod_counter_chk #(
  parameter int UIP_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       freeze,
  input logic       uip,
  input logic [7:0] sec
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= '0;
    else if (uip) hi_cnt <= hi_cnt + 16'd1;
    else hi_cnt <= '0;
  end

  p_uip_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!uip && tick && !freeze) |=> uip);

  p_uip_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> (hi_cnt == 16'(UIP_CYCLES)));

  p_hold_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uip && $past(uip) && !$past(wr_en)) |-> $stable(sec));

  p_change_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(uip) && !$past(wr_en)) |-> $stable(sec));

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!uip && freeze) |=> !uip);

  p_write_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'h0) |=> (sec == $past(wr_data)));
endmodule

bind rtc_tod_counter rtc_tod_counter_chk #(.UIP_CYCLES(UIP_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .freeze(cb_q[7]), .uip(uip), .sec(sec_q)
);

// File: tb/tb_rtc_tod_counter.sv
`timescale 1ns/1ps
module tb_rtc_tod_counter;
  logic clk = 0, rst_n = 0, tick_1hz = 0, wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  rtc_tod_counter dut (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  always #5 clk = ~clk;

  int m[16];
  int nm[16];
  int mu;

  function automatic int fdec(int v, bit b);
    return b ? (v & 127) : ((v >> 4) & 15) * 10 + (v & 15);
  endfunction
  function automatic int fenc(int n, bit b);
    return b ? n : ((n / 10) << 4) | (n % 10);
  endfunction

  task automatic model_advance();
    bit b = m[11][2];
    bit t24 = m[11][1];
    int s, mi, h, h12, d, dm, mo, y, len;
    s = fdec(m[0], b);
    nm[0] = fenc((s + 1) % 60, b);
    if (s != 59) return;
    mi = fdec(m[2], b);
    nm[2] = fenc((mi + 1) % 60, b);
    if (mi != 59) return;
    if (t24) h = fdec(m[4], b);
    else h = (fdec(m[4] & 127, b) % 12) + (m[4][7] ? 12 : 0);
    h = (h + 1) % 24;
    if (t24) nm[4] = fenc(h, b);
    else begin
      h12 = (h % 12 == 0) ? 12 : h % 12;
      nm[4] = (h >= 12 ? 128 : 0) | fenc(h12, b);
    end
    if (h != 0) return;
    d = fdec(m[6], b);
    nm[6] = fenc(d == 7 ? 1 : d + 1, b);
    dm = fdec(m[7], b); mo = fdec(m[8], b); y = fdec(m[9], b);
    if (mo == 2) len = (y % 4 == 0) ? 29 : 28;
    else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) len = 30;
    else len = 31;
    nm[7] = fenc(dm >= len ? 1 : dm + 1, b);
    if (dm < len) return;
    nm[8] = fenc(mo == 12 ? 1 : mo + 1, b);
    if (mo != 12) return;
    nm[9] = fenc(y == 99 ? 0 : y + 1, b);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m[i]) m[i] = 0;
      m[6] = 1; m[7] = 1; m[8] = 1; m[11] = 2; mu = 0;
    end else begin
      nm = m;
      if (mu == 1 && !m[11][7]) model_advance();
      if (mu > 0) mu = mu - 1;
      else if (tick_1hz && !m[11][7]) mu = 4;
      if (wr_en) begin
        if (wr_addr < 10 || wr_addr == 11) nm[wr_addr] = wr_data;
        else if (wr_addr == 10) nm[10] = wr_data & 127;
      end
      m = nm;
    end
  end

  function automatic int mread(int a);
    if (a < 10 || a == 11) return m[a];
    if (a == 10) return m[10] | (mu > 0 ? 128 : 0);
    return 0;
  endfunction

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      checks++;
      if (rd_data !== 8'(mread(rd_addr))) begin
        errors++;
        $display("FAIL R4 cycle model addr=%0h actual=%02h expected=%02h",
                 rd_addr, rd_data, 8'(mread(rd_addr)));
      end
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [7:0] exp);
    @(negedge clk); rd_addr = a; #2;
    chk(tag, rd_data, exp);
  endtask

  task automatic tick_wait();
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                          logic [7:0] dw, logic [7:0] dm, logic [7:0] mo, logic [7:0] y);
    wr(4'h0, s); wr(4'h2, mi); wr(4'h4, h); wr(4'h6, dw);
    wr(4'h7, dm); wr(4'h8, mo); wr(4'h9, y);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk("R1 sec", 4'h0, 8'h00);
    rd_chk("R1 hour", 4'h4, 8'h00);
    rd_chk("R1 dow", 4'h6, 8'h01);
    rd_chk("R1 dom", 4'h7, 8'h01);
    rd_chk("R1 month", 4'h8, 8'h01);
    rd_chk("R1 alarm hour", 4'h5, 8'h00);
    rd_chk("R1 ctrlA", 4'hA, 8'h00);
    rd_chk("R1 ctrlB", 4'hB, 8'h02);
    // R2 map
    wr(4'h1, 8'h33); rd_chk("R2 alarm sec", 4'h1, 8'h33);
    wr(4'h3, 8'h44); rd_chk("R2 alarm min", 4'h3, 8'h44);
    wr(4'hC, 8'hFF); rd_chk("R2 reg C", 4'hC, 8'h00);
    rd_chk("R2 reg F", 4'hF, 8'h00);
    // R12
    wr(4'hA, 8'hFF); rd_chk("R12 ctrlA ro bit", 4'hA, 8'h7F);
    wr(4'hA, 8'h20);
    // R3 / R4 window
    wr(4'h0, 8'h05);
    @(negedge clk); tick_1hz = 1; rd_addr = 4'hA;
    @(negedge clk); tick_1hz = 0; #2; chk("R3 uip high", rd_data, 8'hA0);
    @(negedge clk); rd_addr = 4'h0; #2; chk("R4 old value", rd_data, 8'h05);
    @(negedge clk); rd_addr = 4'hA;
    @(negedge clk); #2; chk("R3 uip last cycle", rd_data, 8'hA0);
    @(negedge clk); #2; chk("R3 uip fell", rd_data, 8'h20);
    rd_chk("R3 sec updated", 4'h0, 8'h06);
    // R5 R7 R9 full cascade BCD 24h
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tick_wait();
    rd_chk("R5 sec wrap", 4'h0, 8'h00);
    rd_chk("R5 min wrap", 4'h2, 8'h00);
    rd_chk("R7 hour wrap", 4'h4, 8'h00);
    rd_chk("R7 dow wrap", 4'h6, 8'h01);
    rd_chk("R9 dom wrap", 4'h7, 8'h01);
    rd_chk("R9 month wrap", 4'h8, 8'h01);
    rd_chk("R9 year wrap", 4'h9, 8'h00);
    // R9 leap February
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    tick_wait(); rd_chk("R9 leap feb 29", 4'h7, 8'h29);
    wr(4'h0, 8'h59); wr(4'h2, 8'h59); wr(4'h4, 8'h23);
    tick_wait(); rd_chk("R9 leap to march day", 4'h7, 8'h01);
    rd_chk("R9 leap to march", 4'h8, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    tick_wait(); rd_chk("R9 non-leap feb", 4'h8, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h23);
    tick_wait(); rd_chk("R9 april 30", 4'h8, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h05, 8'h23);
    tick_wait(); rd_chk("R9 may 31st", 4'h7, 8'h31);
    // R6 binary
    wr(4'hB, 8'h06);
    wr(4'h0, 8'h09); tick_wait(); rd_chk("R6 bin 9->10", 4'h0, 8'h0A);
    set_time(8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1F, 8'h0C, 8'h63);
    tick_wait();
    rd_chk("R6 bin min wrap", 4'h2, 8'h00);
    rd_chk("R6 bin hour wrap", 4'h4, 8'h00);
    rd_chk("R6 bin year wrap", 4'h9, 8'h00);
    // R8 12-hour BCD
    wr(4'hB, 8'h00);
    set_time(8'h59, 8'h59, 8'h11, 8'h02, 8'h10, 8'h06, 8'h20);
    tick_wait(); rd_chk("R8 11AM->12PM", 4'h4, 8'h92);
    wr(4'h0, 8'h59); wr(4'h2, 8'h59);
    tick_wait(); rd_chk("R8 12PM->1PM", 4'h4, 8'h81);
    wr(4'h0, 8'h59); wr(4'h2, 8'h59); wr(4'h4, 8'h91);
    tick_wait(); rd_chk("R8 11PM->12AM", 4'h4, 8'h12);
    rd_chk("R8 day advance", 4'h6, 8'h03);
    wr(4'h0, 8'h59); wr(4'h2, 8'h59);
    tick_wait(); rd_chk("R8 12AM->1AM", 4'h4, 8'h01);
    // R11 mode change keeps values
    wr(4'h4, 8'h92); wr(4'h0, 8'h25);
    wr(4'hB, 8'h02); rd_chk("R11 hour kept", 4'h4, 8'h92);
    wr(4'hB, 8'h06); rd_chk("R11 sec kept", 4'h0, 8'h25);
    wr(4'hB, 8'h02);
    // R10 freeze
    wr(4'h0, 8'h10);
    wr(4'hB, 8'h82);
    @(negedge clk); tick_1hz = 1; rd_addr = 4'hA;
    @(negedge clk); tick_1hz = 0; #2; chk("R10 no uip", rd_data, 8'h20);
    repeat (4) @(negedge clk);
    rd_chk("R10 frozen sec", 4'h0, 8'h10);
    wr(4'hB, 8'h02);
    tick_wait(); rd_chk("R10 resumed", 4'h0, 8'h11);
    // R13 write in commit cycle and tick in window
    wr(4'h0, 8'h59); wr(4'h2, 8'h10);
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    @(negedge clk); wr_en = 1; wr_addr = 4'h0; wr_data = 8'h40;
    @(negedge clk); wr_en = 0; rd_addr = 4'hA; #2;
    chk("R13 window not stretched", rd_data, 8'h20);
    rd_chk("R13 write wins", 4'h0, 8'h40);
    rd_chk("R13 carry kept", 4'h2, 8'h11);
    rd_chk("R13 no second uip", 4'hA, 8'h20);
    repeat (6) @(negedge clk);
    rd_chk("R13 single increment", 4'h0, 8'h40);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule